// File: doc/BRIEF.md
# Coprocessor Operand Transfer Aligner

This block moves operands of different sizes across a single 32-bit operand port. The transmit path takes a right-justified operand value (up to 96 bits) and a 3-bit size code. It emits one, two or three 32-bit words on a valid/ready handshake.

Operands narrower than a word are packed against the most significant byte of the transfer word, and the unused low-order bits are driven to zero. Operands wider than a word are split into long words, and the most significant long word is sent first. The number of transfers therefore follows from the size code.

The receive path works the other way round. It is started with a size code and accepts the matching number of words. It ignores the padding bits of a partial word. When the last word has been accepted, it presents the rebuilt right-justified operand together with a one-cycle valid pulse.

Each path takes a new size code only when it is idle. An unsupported size code raises a one-cycle error flag and starts no transfer.

Top module: `opnd_xfer_aligner`

## Requirements
- R1: Size code 0 (byte) sends one word whose bits 31:24 hold operand bits 7:0 and whose bits 23:0 are zero.
- R2: Size code 1 (word) sends one word whose bits 31:16 hold operand bits 15:0 and whose bits 15:0 are zero.
- R3: Size code 2 (three-byte) sends one word whose bits 31:8 hold operand bits 23:0 and whose bits 7:0 are zero.
- R4: Size code 3 (long or single) sends one word equal to operand bits 31:0.
- R5: Size code 4 (double) sends two words: operand bits 63:32 first, then bits 31:0.
- R6: Size code 5 (extended or packed decimal) sends three words: operand bits 95:64, then 63:32, then 31:0.
- R7: Size codes 6 and 7 are unsupported. On the transmit side, tx_err is high for exactly one cycle after the start and tx_valid stays low. On the receive side, rx_err is high for exactly one cycle after the start and rx_ready stays low.
- R8: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data stays unchanged in the next cycle.
- R9: The receive path rebuilds the operand right-justified on opnd_out. Bits above the operand size are zero, and the padding bits of a partial word (for example bits 23:0 for a byte) have no effect on the result.
- R10: opnd_valid is high for exactly one cycle, the cycle after the edge that accepts the last word, and it is low at all other times.
- R11: A start request that arrives while the path is busy is ignored. The running transfer keeps its size and data, and no extra transfer follows it.
- R12: After reset, tx_valid, rx_ready, opnd_valid, tx_err and rx_err are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start | input | 1 | Begin sending an operand (taken only when idle) |
| tx_size | input | 3 | Size code for the operand to send |
| tx_operand | input | 96 | Right-justified operand to send |
| tx_err | output | 1 | One-cycle flag for an unsupported transmit size code |
| tx_data | output | 32 | Outgoing transfer word |
| tx_valid | output | 1 | Outgoing word is valid |
| tx_ready | input | 1 | Receiver accepts the outgoing word |
| rx_start | input | 1 | Begin collecting an operand (taken only when idle) |
| rx_size | input | 3 | Size code of the operand to collect |
| rx_err | output | 1 | One-cycle flag for an unsupported receive size code |
| rx_data | input | 32 | Incoming transfer word |
| rx_valid | input | 1 | Incoming word is valid |
| rx_ready | output | 1 | Block accepts an incoming word |
| opnd_out | output | 96 | Rebuilt right-justified operand |
| opnd_valid | output | 1 | One-cycle pulse when opnd_out is new |

## Verification
The bench targets packing of the partial sizes. A design that shifted by the wrong amount, or that left operand bits above the size in the word, would put data in the padding or misplace the top byte.

The bench also checks word order for double and extended operands, where a reversed design would send the least significant word first. Receive words carry random padding bits, so a design that kept those bits would corrupt opnd_out.

Further checks cover a stalled tx_ready, start requests issued in the middle of a transfer, and the unsupported codes 6 and 7. On these, a faulty design would drop or change data, restart, or begin a spurious transfer.

// File: rtl/opxfer_pkg.sv
package opxfer_pkg;

  localparam int XFER_W   = 32;
  localparam int XFER_MAX = 3;

  typedef enum logic [2:0] {
    SZ_BYTE   = 3'd0,
    SZ_WORD   = 3'd1,
    SZ_TRIPLE = 3'd2,
    SZ_LONG   = 3'd3,
    SZ_DOUBLE = 3'd4,
    SZ_WIDE   = 3'd5
  } size_code_e;

  function automatic logic size_ok(input logic [2:0] code);
    return (code <= 3'd5);
  endfunction

  // Number of transfer words an operand of this size needs.
  function automatic int unsigned size_words(input logic [2:0] code);
    case (code)
      3'd4:    return 2;
      3'd5:    return 3;
      default: return 1;
    endcase
  endfunction

  // Operand width in bits.
  function automatic int unsigned size_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 16;
      3'd2:    return 24;
      3'd3:    return XFER_W;
      3'd4:    return 2 * XFER_W;
      default: return 3 * XFER_W;
    endcase
  endfunction

endpackage

// File: rtl/opxfer_tx.sv
module opxfer_tx
  import opxfer_pkg::*;
#(
  parameter int WORD_W    = XFER_W,
  parameter int MAX_WORDS = XFER_MAX
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [2:0]                  size,
  input  logic [WORD_W*MAX_WORDS-1:0] operand,
  output logic                        err,
  output logic [WORD_W-1:0]           data,
  output logic                        valid,
  input  logic                        ready
);
  localparam int OPND_W = WORD_W * MAX_WORDS;
  localparam int CNT_W  = $clog2(MAX_WORDS + 1);

  logic [OPND_W-1:0] shreg;
  logic [CNT_W-1:0]  left;
  logic [2:0]        cur_size;
  logic [OPND_W-1:0] aligned;

  // Mask off bits above the operand size, then push the operand to the top.
  always_comb begin
    logic [OPND_W-1:0] masked;
    int unsigned bits;
    bits = size_bits(size);
    for (int i = 0; i < OPND_W; i++) begin
      masked[i] = (i < bits) ? operand[i] : 1'b0;
    end
    aligned = masked << (OPND_W - bits);
  end

  assign data = shreg[OPND_W-1 -: WORD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      left     <= '0;
      valid    <= 1'b0;
      err      <= 1'b0;
      cur_size <= 3'd0;
    end else begin
      err <= 1'b0;
      if (!valid) begin
        if (start) begin
          if (size_ok(size)) begin
            shreg    <= aligned;
            left     <= CNT_W'(size_words(size));
            cur_size <= size;
            valid    <= 1'b1;
          end else begin
            err <= 1'b1;
          end
        end
      end else if (ready) begin
        shreg <= shreg << WORD_W;
        left  <= left - 1'b1;
        if (left == CNT_W'(1)) valid <= 1'b0;
      end
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(data)));               // R8
  AST_TX_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    err |-> !valid);                                               // R7
  AST_TX_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);                                                 // R7
  AST_TX_BYTE_PAD: assert property (@(posedge clk) disable iff (rst)
    (valid && cur_size == SZ_BYTE) |-> (data[WORD_W-9:0] == '0));  // R1
  AST_TX_WORD_PAD: assert property (@(posedge clk) disable iff (rst)
    (valid && cur_size == SZ_WORD) |-> (data[WORD_W-17:0] == '0)); // R2
  AST_TX_TRIPLE_PAD: assert property (@(posedge clk) disable iff (rst)
    (valid && cur_size == SZ_TRIPLE) |-> (data[WORD_W-25:0] == '0)); // R3
  AST_TX_SIZE_LOCK: assert property (@(posedge clk) disable iff (rst)
    (valid && $past(valid)) |-> $stable(cur_size));                // R11

endmodule

// File: rtl/opxfer_rx.sv
module opxfer_rx
  import opxfer_pkg::*;
#(
  parameter int WORD_W    = XFER_W,
  parameter int MAX_WORDS = XFER_MAX
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [2:0]                  size,
  output logic                        err,
  input  logic [WORD_W-1:0]           data,
  input  logic                        valid,
  output logic                        ready,
  output logic [WORD_W*MAX_WORDS-1:0] operand,
  output logic                        done
);
  localparam int OPND_W = WORD_W * MAX_WORDS;
  localparam int CNT_W  = $clog2(MAX_WORDS + 1);

  logic [OPND_W-1:0] acc;
  logic [OPND_W-1:0] acc_next;
  logic [OPND_W-1:0] rebuilt;
  logic [CNT_W-1:0]  left;
  logic [2:0]        cur_size;

  assign acc_next = {acc[OPND_W-WORD_W-1:0], data};

  // Words collected so far sit in the low part of acc_next; drop padding.
  always_comb begin
    int unsigned drop;
    drop    = size_words(cur_size) * WORD_W - size_bits(cur_size);
    rebuilt = acc_next >> drop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      left     <= '0;
      ready    <= 1'b0;
      err      <= 1'b0;
      done     <= 1'b0;
      operand  <= '0;
      cur_size <= 3'd0;
    end else begin
      err  <= 1'b0;
      done <= 1'b0;
      if (!ready) begin
        if (start) begin
          if (size_ok(size)) begin
            acc      <= '0;
            left     <= CNT_W'(size_words(size));
            cur_size <= size;
            ready    <= 1'b1;
          end else begin
            err <= 1'b1;
          end
        end
      end else if (valid) begin
        acc  <= acc_next;
        left <= left - 1'b1;
        if (left == CNT_W'(1)) begin
          ready   <= 1'b0;
          done    <= 1'b1;
          operand <= rebuilt;
        end
      end
    end
  end

  AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                               // R10
  AST_RX_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(ready) && $past(valid) && !ready));     // R10
  AST_RX_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    err |-> !ready);                                               // R7
  AST_RX_BYTE_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && cur_size == SZ_BYTE) |-> (operand[OPND_W-1:8] == '0)); // R9

endmodule

// File: rtl/opnd_xfer_aligner.sv
module opnd_xfer_aligner
  import opxfer_pkg::*;
#(
  parameter int WORD_W    = XFER_W,
  parameter int MAX_WORDS = XFER_MAX
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tx_start,
  input  logic [2:0]                  tx_size,
  input  logic [WORD_W*MAX_WORDS-1:0] tx_operand,
  output logic                        tx_err,
  output logic [WORD_W-1:0]           tx_data,
  output logic                        tx_valid,
  input  logic                        tx_ready,
  input  logic                        rx_start,
  input  logic [2:0]                  rx_size,
  output logic                        rx_err,
  input  logic [WORD_W-1:0]           rx_data,
  input  logic                        rx_valid,
  output logic                        rx_ready,
  output logic [WORD_W*MAX_WORDS-1:0] opnd_out,
  output logic                        opnd_valid
);

  opxfer_tx #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS)) u_tx (
    .clk(clk), .rst(rst), .start(tx_start), .size(tx_size),
    .operand(tx_operand), .err(tx_err), .data(tx_data),
    .valid(tx_valid), .ready(tx_ready)
  );

  opxfer_rx #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS)) u_rx (
    .clk(clk), .rst(rst), .start(rx_start), .size(rx_size),
    .err(rx_err), .data(rx_data), .valid(rx_valid), .ready(rx_ready),
    .operand(opnd_out), .done(opnd_valid)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !(tx_valid || rx_ready || opnd_valid || tx_err || rx_err)); // R12

endmodule

// File: tb/opnd_xfer_aligner_tb.sv
module opnd_xfer_aligner_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_start = 1'b0;
  logic [2:0]  tx_size = 3'd0;
  logic [95:0] tx_operand = '0;
  logic        tx_err;
  logic [31:0] tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic        rx_start = 1'b0;
  logic [2:0]  rx_size = 3'd0;
  logic        rx_err;
  logic [31:0] rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [95:0] opnd_out;
  logic        opnd_valid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  opnd_xfer_aligner u_dut (
    .clk(clk), .rst(rst),
    .tx_start(tx_start), .tx_size(tx_size), .tx_operand(tx_operand),
    .tx_err(tx_err), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_start(rx_start), .rx_size(rx_size), .rx_err(rx_err),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .opnd_out(opnd_out), .opnd_valid(opnd_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] s);
    case (s)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic int nwords(input logic [2:0] s);
    return (s == 3'd4) ? 2 : (s == 3'd5) ? 3 : 1;
  endfunction

  // Expected k-th transfer word for an operand of size s.
  function automatic logic [31:0] exp_word(input logic [2:0] s, input logic [95:0] op, input int k);
    case (s)
      3'd0: return {op[7:0], 24'h0};
      3'd1: return {op[15:0], 16'h0};
      3'd2: return {op[23:0], 8'h0};
      3'd3: return op[31:0];
      3'd4: return (k == 0) ? op[63:32] : op[31:0];
      default: return (k == 0) ? op[95:64] : (k == 1) ? op[63:32] : op[31:0];
    endcase
  endfunction

  function automatic logic [31:0] pad_mask(input logic [2:0] s);
    case (s)
      3'd0: return 32'h00FF_FFFF;
      3'd1: return 32'h0000_FFFF;
      3'd2: return 32'h0000_00FF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [95:0] exp_opnd(input logic [2:0] s, input logic [95:0] op);
    case (s)
      3'd0: return {88'h0, op[7:0]};
      3'd1: return {80'h0, op[15:0]};
      3'd2: return {72'h0, op[23:0]};
      3'd3: return {64'h0, op[31:0]};
      3'd4: return {32'h0, op[63:0]};
      default: return op;
    endcase
  endfunction

  function automatic logic [95:0] rnd96();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  task automatic run_tx(input logic [2:0] s, input logic [95:0] op, input bit stall, input bit intrude);
    int got;
    int guard;
    logic [31:0] held;
    bit was_stalled;
    @(negedge clk);
    tx_start = 1'b1; tx_size = s; tx_operand = op;
    @(negedge clk);
    tx_start = 1'b0;
    if (s > 3'd5) begin
      check("R7 tx_err pulse", {95'h0, tx_err}, 96'h1);
      check("R7 tx_valid low", {95'h0, tx_valid}, 96'h0);
      @(negedge clk);
      check("R7 tx_err one cycle", {95'h0, tx_err}, 96'h0);
      check("R7 no transfer", {95'h0, tx_valid}, 96'h0);
      return;
    end
    got = 0; guard = 0; was_stalled = 0; held = '0;
    while (got < nwords(s) && guard < 200) begin
      guard++;
      if (was_stalled) begin
        check("R8 stalled hold valid", {95'h0, tx_valid}, 96'h1);
        check("R8 stalled hold data", {64'h0, tx_data}, {64'h0, held});
      end
      tx_ready = stall ? 1'($urandom_range(0, 1)) : 1'b1;
      if (intrude) begin
        tx_start = 1'b1; tx_size = 3'd3; tx_operand = rnd96();
      end
      if (!tx_valid) begin
        check({req_of(s), " valid during transfer"}, {95'h0, tx_valid}, 96'h1);
        got = nwords(s);
      end else if (tx_ready) begin
        check({req_of(s), intrude ? " R11 word" : " word"}, {64'h0, tx_data},
              {64'h0, exp_word(s, op, got)});
        got++;
        was_stalled = 0;
      end else begin
        held = tx_data;
        was_stalled = 1;
      end
      @(negedge clk);
      tx_start = 1'b0;
    end
    tx_ready = 1'b0;
    check({req_of(s), " R11 no extra transfer"}, {95'h0, tx_valid}, 96'h0);
  endtask

  task automatic run_rx(input logic [2:0] s, input logic [95:0] op, input bit bubble, input bit intrude);
    int got;
    int guard;
    @(negedge clk);
    rx_start = 1'b1; rx_size = s;
    @(negedge clk);
    rx_start = 1'b0;
    if (s > 3'd5) begin
      check("R7 rx_err pulse", {95'h0, rx_err}, 96'h1);
      check("R7 rx_ready low", {95'h0, rx_ready}, 96'h0);
      @(negedge clk);
      check("R7 rx_err one cycle", {95'h0, rx_err}, 96'h0);
      check("R7 rx_ready stays low", {95'h0, rx_ready}, 96'h0);
      return;
    end
    got = 0; guard = 0;
    while (got < nwords(s) && guard < 200) begin
      guard++;
      rx_valid = bubble ? 1'($urandom_range(0, 1)) : 1'b1;
      rx_data  = exp_word(s, op, got) | ($urandom() & pad_mask(s));
      if (intrude) begin
        rx_start = 1'b1; rx_size = 3'd0;
      end
      if (!rx_ready) begin
        check("R9 rx_ready while collecting", {95'h0, rx_ready}, 96'h1);
        got = nwords(s);
      end else if (rx_valid) begin
        got++;
      end
      if (opnd_valid) check("R10 no early pulse", {95'h0, opnd_valid}, 96'h0);
      @(negedge clk);
      rx_start = 1'b0;
    end
    rx_valid = 1'b0;
    check("R10 pulse after last word", {95'h0, opnd_valid}, 96'h1);
    check({"R9 rebuild ", req_of(s)}, opnd_out, exp_opnd(s, op));
    @(negedge clk);
    check("R10 pulse one cycle", {95'h0, opnd_valid}, 96'h0);
    check("R11 rx start while busy ignored", {95'h0, rx_ready}, 96'h0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R12 tx_valid reset", {95'h0, tx_valid}, 96'h0);
    check("R12 rx_ready reset", {95'h0, rx_ready}, 96'h0);
    check("R12 opnd_valid reset", {95'h0, opnd_valid}, 96'h0);
    check("R12 errors reset", {94'h0, tx_err, rx_err}, 96'h0);
    rst = 1'b0;

    // Directed: all ones exposes stray bits above the size and in padding.
    for (int s = 0; s < 8; s++) run_tx(3'(s), {96{1'b1}}, 1'b0, 1'b0);
    for (int s = 0; s < 8; s++) run_rx(3'(s), {96{1'b1}}, 1'b0, 1'b0);
    run_tx(3'd5, 96'h0102_0304_0506_0708_090A_0B0C, 1'b1, 1'b0);
    run_tx(3'd4, 96'hFFFF_FFFF_8000_0001_7FFF_FFFE, 1'b0, 1'b1);
    run_rx(3'd5, 96'hA1A2_A3A4_B1B2_B3B4_C1C2_C3C4, 1'b1, 1'b1);

    // Random mix.
    for (int i = 0; i < 300; i++) begin
      logic [2:0] s;
      s = 3'($urandom_range(0, 7));
      run_tx(s, rnd96(), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      run_rx(3'($urandom_range(0, 7)), rnd96(), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule